// File: doc/BRIEF.md
# Short I/O Slave Address Decoder

This block sits at the bus edge of a peripheral card on a parallel backplane with a 16-bit short I/O address space. It watches each bus transfer and decides whether the transfer belongs to the card. The card occupies one 1 Kbyte window that starts on a 1 Kbyte boundary. A 6-bit base select input picks the window, and it is compared with the upper address bits. The address modifier code must name short I/O space. A privilege option input decides whether only supervisory cycles are accepted, or supervisory and non-privileged cycles both.

The card is an odd-byte slave. A single-byte transfer on the odd lane is accepted. A 16-bit word transfer is also accepted, but only its odd lane carries data. A single-byte transfer on the even lane gets no response at all. Long-word transfers, interrupt-acknowledge cycles and all other modifier codes are also ignored. For an accepted transfer the block raises a local chip select. It latches a 9-bit register offset, a byte-lane code and a write flag for the local register file. One clock later it raises the acknowledge, and it holds it until both data strobes are released.

Control is a four-state machine:
- IDLE waits for the address strobe with at least one data strobe. It goes to SELECT on a full decode hit, and to SKIP on a miss.
- SELECT drives the chip select. It moves to ACKNOWLEDGE while a data strobe is still active, or back to IDLE if the strobes were withdrawn (abort).
- ACKNOWLEDGE drives select and acknowledge. It returns to IDLE once both data strobes are high.
- SKIP returns to IDLE once both data strobes are high, without ever responding.

Top module: `sio_slave_decoder`

## Requirements
- R1: Chip select rises only when address bits 15..10 equal `base_sel`; `reg_off` then carries address bits 9..1 of that transfer.
- R2: With `super_only` high only modifier 0x2D is accepted; with it low 0x2D and 0x29 are accepted; every other modifier code gets no select and no acknowledge.
- R3: A transfer with `ds1_n` (even lane) low and `ds0_n` (odd lane) high gets no select and no acknowledge.
- R4: Odd byte (`ds0_n` low, `ds1_n` high, `lword_n` high) is accepted with `lane_sel` = 2'b01; word (both strobes low, `lword_n` high) is accepted with `lane_sel` = 2'b11; bit 0 means the odd lane carries data, bit 1 means the even lane is strobed but carries no data.
- R5: A transfer with `lword_n` low gets no response.
- R6: A transfer while `iack_n` is low gets no response.
- R7: Chip select rises on the clock after the strobes are first seen with a hit. The acknowledge rises one clock later and stays high while any data strobe is low. It falls on the first clock that sees both strobes high.
- R8: After reset `cs`, `ack`, `reg_off`, `lane_sel` and `loc_we` are all zero.
- R9: `loc_we` equals the inverse of `write_n` at decode; `reg_off`, `lane_sel` and `loc_we` stay stable while `cs` is high.
- R10: After a miss, the block stays silent until both data strobes are released, even if the address turns into a hit while the strobes are held.
- R11: If both data strobes are withdrawn while in SELECT, the block returns to idle without ever raising the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_sel | input | 6 | Window base, compared with address bits 15..10 |
| super_only | input | 1 | 1: supervisory modifier only; 0: also non-privileged |
| bus_addr | input | 15 | Bus address bits 15..1 |
| bus_am | input | 6 | Address modifier code |
| as_n | input | 1 | Address strobe, active low |
| ds0_n | input | 1 | Odd-lane data strobe, active low |
| ds1_n | input | 1 | Even-lane data strobe, active low |
| lword_n | input | 1 | Long-word flag, active low |
| write_n | input | 1 | Low for a write transfer |
| iack_n | input | 1 | Interrupt acknowledge, active low |
| cs | output | 1 | Local chip select |
| ack | output | 1 | Transfer acknowledge, active high |
| reg_off | output | 9 | Local register offset (address bits 9..1) |
| lane_sel | output | 2 | Byte-lane code: 01 odd byte, 11 word, 00 idle |
| loc_we | output | 1 | Local write enable for the accepted transfer |

## Verification
The assertions assume that every bus input is already synchronous to `clk`. They also assume that address, modifier, long-word and write stay steady while the block holds select. The checks compare decode-time inputs through `$past` at the rising edge of select. The stimulus changes all inputs one nanosecond after a falling clock edge. It keeps them fixed for whole clocks and changes the address mid-transfer only in the skip case, where select never rises. Each transfer is followed by idle clocks with all strobes high, so every transfer starts from IDLE.

// File: rtl/sio_dec_pkg.sv
package sio_dec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEL  = 2'd1,
        ST_ACK  = 2'd2,
        ST_SKIP = 2'd3
    } sio_state_t;

    typedef enum logic [1:0] {
        LANE_NONE = 2'b00,
        LANE_ODD  = 2'b01,
        LANE_WORD = 2'b11
    } sio_lane_t;

    localparam int AM_W = 6;
    localparam logic [AM_W-1:0] AM_SHORT_SUP = 6'h2D;
    localparam logic [AM_W-1:0] AM_SHORT_USR = 6'h29;

endpackage

// File: rtl/sio_win_match.sv
module sio_win_match #(
    parameter int ADDR_W = 16,
    parameter int WIN_W  = 10
) (
    input  logic [ADDR_W-1:1]      addr,
    input  logic [ADDR_W-WIN_W-1:0] base,
    output logic                   hit,
    output logic [WIN_W-2:0]       off
);
    localparam int BASE_W = ADDR_W - WIN_W;

    logic [BASE_W-1:0] upper;

    always_comb begin
        upper = addr[ADDR_W-1:WIN_W];
        hit   = (upper == base);
        off   = addr[WIN_W-1:1];
    end

endmodule

// File: rtl/sio_am_filter.sv
module sio_am_filter
    import sio_dec_pkg::*;
(
    input  logic [AM_W-1:0] am,
    input  logic            super_only,
    output logic            ok
);
    logic is_sup;
    logic is_usr;

    always_comb begin
        is_sup = (am == AM_SHORT_SUP);
        is_usr = (am == AM_SHORT_USR);
        ok     = is_sup || (is_usr && !super_only);
    end

endmodule

// File: rtl/sio_lane_qual.sv
module sio_lane_qual
    import sio_dec_pkg::*;
(
    input  logic      ds0_n,
    input  logic      ds1_n,
    input  logic      lword_n,
    output logic      ok,
    output sio_lane_t lane
);
    always_comb begin
        ok   = lword_n && !ds0_n;
        lane = ds1_n ? LANE_ODD : LANE_WORD;
    end

endmodule

// File: rtl/sio_ctrl_fsm.sv
module sio_ctrl_fsm
    import sio_dec_pkg::*;
#(
    parameter int OFF_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             hit,
    input  logic             any_ds,
    input  logic [OFF_W-1:0] off_in,
    input  sio_lane_t        lane_in,
    input  logic             we_in,
    output logic             cs,
    output logic             ack,
    output logic [OFF_W-1:0] off_q,
    output sio_lane_t        lane_q,
    output logic             we_q
);
    sio_state_t st_q;
    sio_state_t st_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE: if (start) st_nxt = hit ? ST_SEL : ST_SKIP;
            ST_SEL:  st_nxt = any_ds ? ST_ACK : ST_IDLE;
            ST_ACK:  if (!any_ds) st_nxt = ST_IDLE;
            ST_SKIP: if (!any_ds) st_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        cs  = 1'b0;
        ack = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_SEL:  cs = 1'b1;
            ST_ACK: begin
                cs  = 1'b1;
                ack = 1'b1;
            end
            ST_SKIP: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q  <= '0;
            lane_q <= LANE_NONE;
            we_q   <= 1'b0;
        end else if (st_q == ST_IDLE && st_nxt == ST_SEL) begin
            off_q  <= off_in;
            lane_q <= lane_in;
            we_q   <= we_in;
        end else if (st_q != ST_IDLE && st_nxt == ST_IDLE) begin
            off_q  <= '0;
            lane_q <= LANE_NONE;
            we_q   <= 1'b0;
        end
    end

endmodule

// File: rtl/sio_slave_decoder.sv
module sio_slave_decoder
    import sio_dec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WIN_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-WIN_W-1:0] base_sel,
    input  logic                    super_only,
    input  logic [ADDR_W-1:1]       bus_addr,
    input  logic [5:0]              bus_am,
    input  logic                    as_n,
    input  logic                    ds0_n,
    input  logic                    ds1_n,
    input  logic                    lword_n,
    input  logic                    write_n,
    input  logic                    iack_n,
    output logic                    cs,
    output logic                    ack,
    output logic [WIN_W-2:0]        reg_off,
    output logic [1:0]              lane_sel,
    output logic                    loc_we
);
    localparam int OFF_W = WIN_W - 1;

    logic             win_hit;
    logic [OFF_W-1:0] win_off;
    logic             am_ok;
    logic             lane_ok;
    sio_lane_t        lane_d;
    sio_lane_t        lane_q;
    logic             any_ds;
    logic             start;
    logic             hit;

    sio_win_match #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_win (
        .addr (bus_addr),
        .base (base_sel),
        .hit  (win_hit),
        .off  (win_off)
    );

    sio_am_filter u_am (
        .am         (bus_am),
        .super_only (super_only),
        .ok         (am_ok)
    );

    sio_lane_qual u_lane (
        .ds0_n   (ds0_n),
        .ds1_n   (ds1_n),
        .lword_n (lword_n),
        .ok      (lane_ok),
        .lane    (lane_d)
    );

    always_comb begin
        any_ds = !ds0_n || !ds1_n;
        start  = !as_n && any_ds;
        hit    = win_hit && am_ok && lane_ok && iack_n;
    end

    sio_ctrl_fsm #(.OFF_W(OFF_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .hit     (hit),
        .any_ds  (any_ds),
        .off_in  (win_off),
        .lane_in (lane_d),
        .we_in   (!write_n),
        .cs      (cs),
        .ack     (ack),
        .off_q   (reg_off),
        .lane_q  (lane_q),
        .we_q    (loc_we)
    );

    assign lane_sel = lane_q;

endmodule

// File: rtl/sio_slave_decoder_chk.sv
module sio_slave_decoder_chk #(
    parameter int ADDR_W = 16,
    parameter int WIN_W  = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-WIN_W-1:0] base_sel,
    input logic                    super_only,
    input logic [ADDR_W-1:1]       bus_addr,
    input logic [5:0]              bus_am,
    input logic                    ds0_n,
    input logic                    ds1_n,
    input logic                    lword_n,
    input logic                    iack_n,
    input logic                    cs,
    input logic                    ack,
    input logic [WIN_W-2:0]        reg_off,
    input logic [1:0]              lane_sel,
    input logic                    loc_we
);
    // R1
    win_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs) |-> $past(bus_addr[ADDR_W-1:WIN_W]) == $past(base_sel));

    // R1
    win_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs) |-> reg_off == $past(bus_addr[WIN_W-1:1]));

    // R2
    am_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs) |-> ($past(bus_am) == 6'h2D ||
                       (!$past(super_only) && $past(bus_am) == 6'h29)));

    // R3
    odd_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs) |-> !$past(ds0_n));

    // R4
    lane_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs |-> (lane_sel == 2'b01 || lane_sel == 2'b11));

    // R5
    no_lword_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs) |-> $past(lword_n));

    // R6
    no_iack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs) |-> $past(iack_n));

    // R7
    ack_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(cs));

    // R7
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ds0_n && ds1_n) |=> !ack);

    // R7
    ack_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> cs);

    // R9
    field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && $past(cs)) |-> ($stable(reg_off) && $stable(lane_sel) && $stable(loc_we)));

endmodule

bind sio_slave_decoder sio_slave_decoder_chk #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_sel   (base_sel),
    .super_only (super_only),
    .bus_addr   (bus_addr),
    .bus_am     (bus_am),
    .ds0_n      (ds0_n),
    .ds1_n      (ds1_n),
    .lword_n    (lword_n),
    .iack_n     (iack_n),
    .cs         (cs),
    .ack        (ack),
    .reg_off    (reg_off),
    .lane_sel   (lane_sel),
    .loc_we     (loc_we)
);

// File: tb/test_sio_slave_decoder.sv
`timescale 1ns/1ps
module test_sio_slave_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  base_sel = 6'h05;
    logic        super_only = 1'b0;
    logic [15:1] bus_addr = '0;
    logic [5:0]  bus_am = 6'h00;
    logic        as_n = 1'b1;
    logic        ds0_n = 1'b1;
    logic        ds1_n = 1'b1;
    logic        lword_n = 1'b1;
    logic        write_n = 1'b1;
    logic        iack_n = 1'b1;
    logic        cs;
    logic        ack;
    logic [8:0]  reg_off;
    logic [1:0]  lane_sel;
    logic        loc_we;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    sio_slave_decoder i_sio_slave_decoder (
        .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .super_only(super_only),
        .bus_addr(bus_addr), .bus_am(bus_am), .as_n(as_n), .ds0_n(ds0_n),
        .ds1_n(ds1_n), .lword_n(lword_n), .write_n(write_n), .iack_n(iack_n),
        .cs(cs), .ack(ack), .reg_off(reg_off), .lane_sel(lane_sel), .loc_we(loc_we)
    );

    typedef struct {
        bit         hit;
        logic [8:0] off;
        logic [1:0] lane;
        bit         we;
        int         acks;
        string      tag;
    } exp_t;

    exp_t sbq[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Driver: one bus transfer, expectation pushed before it starts
    task automatic bus_xfer(input logic [5:0] base, input logic [8:0] off,
                            input logic [5:0] am, input bit d0n, input bit d1n,
                            input bit lwn, input bit wrn, input bit iackn,
                            input int hold, input bit hit, input logic [1:0] lane,
                            input string tag);
        exp_t e;
        e.hit  = hit;
        e.off  = hit ? off : 9'h0;
        e.lane = hit ? lane : 2'b00;
        e.we   = hit ? !wrn : 1'b0;
        e.acks = hit ? hold - 1 : 0;
        e.tag  = tag;
        sbq.push_back(e);
        @(negedge clk); #1;
        bus_addr = {base, off};
        bus_am   = am;
        lword_n  = lwn;
        write_n  = wrn;
        iack_n   = iackn;
        as_n     = 1'b0;
        ds0_n    = d0n;
        ds1_n    = d1n;
        repeat (hold) @(negedge clk);
        #1;
        as_n  = 1'b1;
        ds0_n = 1'b1;
        ds1_n = 1'b1;
        iack_n = 1'b1;
        lword_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Monitor: accumulate observations per transfer and compare at its end
    int         n_in = 0;
    bit         seen_cs = 0;
    int         first_cs = 0;
    int         acks = 0;
    logic [8:0] o_off;
    logic [1:0] o_lane;
    bit         o_we;
    bit         active = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!as_n) begin
                n_in++;
                active = 1;
                if (cs && !seen_cs) begin
                    seen_cs  = 1;
                    first_cs = n_in;
                    o_off    = reg_off;
                    o_lane   = lane_sel;
                    o_we     = loc_we;
                end
                if (ack) acks++;
            end else if (active) begin
                exp_t e;
                active = 0;
                if (sbq.size() == 0) begin
                    chk(0, "R7", "unexpected transfer", 0, 1);
                end else begin
                    e = sbq.pop_front();
                    chk(seen_cs == e.hit, e.tag, "select seen", seen_cs, e.hit);
                    chk(acks == e.acks, e.tag, "ack clocks", acks, e.acks);
                    chk(!cs && !ack, e.tag, "released after strobes (R7)", {cs, ack}, 0);
                    if (e.hit && seen_cs) begin
                        chk(first_cs == 1, e.tag, "select delay (R7)", first_cs, 1);
                        chk(o_off == e.off, e.tag, "offset (R1)", o_off, e.off);
                        chk(o_lane == e.lane, e.tag, "lane (R4)", o_lane, e.lane);
                        chk(o_we == e.we, e.tag, "write enable (R9)", o_we, e.we);
                    end
                end
                n_in = 0; seen_cs = 0; first_cs = 0; acks = 0;
            end
        end
    end

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk(cs == 0 && ack == 0, "R8", "cs/ack in reset", {cs, ack}, 0);
        chk(reg_off == 0 && lane_sel == 0 && loc_we == 0, "R8", "fields in reset",
            {reg_off, lane_sel, loc_we}, 0);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs == 0 && ack == 0, "R8", "idle after reset", {cs, ack}, 0);

        // R4 odd byte read, R1 offset
        bus_xfer(6'h05, 9'h0A3, 6'h2D, 0, 1, 1, 1, 1, 4, 1, 2'b01, "R4");
        // R4 word write, non-privileged allowed
        bus_xfer(6'h05, 9'h155, 6'h29, 0, 0, 1, 0, 1, 4, 1, 2'b11, "R4");
        // R2 privilege option
        super_only = 1'b1;
        bus_xfer(6'h05, 9'h010, 6'h29, 0, 1, 1, 1, 1, 3, 0, 2'b00, "R2");
        bus_xfer(6'h05, 9'h011, 6'h2D, 0, 1, 1, 0, 1, 3, 1, 2'b01, "R2");
        super_only = 1'b0;
        bus_xfer(6'h05, 9'h012, 6'h3D, 0, 1, 1, 1, 1, 3, 0, 2'b00, "R2");
        bus_xfer(6'h05, 9'h013, 6'h09, 0, 0, 1, 1, 1, 3, 0, 2'b00, "R2");
        // R3 even single byte
        bus_xfer(6'h05, 9'h020, 6'h2D, 1, 0, 1, 1, 1, 3, 0, 2'b00, "R3");
        // R5 long word
        bus_xfer(6'h05, 9'h021, 6'h2D, 0, 0, 0, 1, 1, 3, 0, 2'b00, "R5");
        // R6 interrupt acknowledge
        bus_xfer(6'h05, 9'h022, 6'h2D, 0, 1, 1, 1, 0, 3, 0, 2'b00, "R6");
        // R1 wrong window, top window, bottom window
        bus_xfer(6'h06, 9'h023, 6'h2D, 0, 1, 1, 1, 1, 3, 0, 2'b00, "R1");
        base_sel = 6'h3F;
        bus_xfer(6'h3F, 9'h1FF, 6'h2D, 0, 1, 1, 0, 1, 3, 1, 2'b01, "R1");
        base_sel = 6'h00;
        bus_xfer(6'h00, 9'h000, 6'h29, 0, 0, 1, 1, 1, 3, 1, 2'b11, "R1");
        base_sel = 6'h05;
        // R11 abort in select
        bus_xfer(6'h05, 9'h0F0, 6'h2D, 0, 1, 1, 1, 1, 1, 1, 2'b01, "R11");
        // R7 long hold
        bus_xfer(6'h05, 9'h0F1, 6'h2D, 0, 0, 1, 0, 1, 7, 1, 2'b11, "R7");
        // R9 write flag with odd byte
        bus_xfer(6'h05, 9'h0F2, 6'h2D, 0, 1, 1, 0, 1, 3, 1, 2'b01, "R9");

        // R10 miss, then address becomes a hit while strobes are held
        begin
            exp_t e;
            e.hit = 0; e.off = 0; e.lane = 0; e.we = 0; e.acks = 0; e.tag = "R10";
            sbq.push_back(e);
            @(negedge clk); #1;
            bus_addr = {6'h07, 9'h044};
            bus_am = 6'h2D; write_n = 1'b1;
            as_n = 1'b0; ds0_n = 1'b0; ds1_n = 1'b1;
            @(negedge clk); #1;
            bus_addr = {6'h05, 9'h044};
            repeat (3) @(negedge clk);
            #1;
            as_n = 1'b1; ds0_n = 1'b1; ds1_n = 1'b1;
            repeat (2) @(negedge clk);
        end

        repeat (3) @(negedge clk);
        chk(sbq.size() == 0, "R7", "scoreboard drained", sbq.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule